// File: doc/BRIEF.md
# Flash Protection Install Lifecycle Tracker

This block follows each of up to three flash user configuration blocks through their life: erased, configured (keyword page written), confirmed (confirmation page written), installed (confirmation word correct) and active (installed and a system reset has since occurred). It reacts to single-cycle command pulses from a flash command decoder: program the configuration page, program the confirmation page, erase a configuration block, and system reset. Registers stand in for the stored pages. The block holds the two keywords, the protection type and the confirmation word of each block.

It drives per-block configured, installed and active flags, a global installed flag, a read-protection-active flag, a keyword match indication against the key inputs, and the lifetime erase counts. Illegal requests leave the stored state as it was and raise a sticky reject flag. The last block is the one-time-programmable one: it cannot be erased once installed. The other blocks have a limited erase budget.

Top module: `flash_prot_lifecycle`

## Requirements
- R1: A configuration-page program to an unconfigured block, with `pad_i` zero, stores `ptype_i`, `key0_i` and `key1_i` and sets `configured_o[b]`. `key_ok_o[b]` is high exactly when block b is configured and both stored keywords equal `key0_i`/`key1_i`.
- R2: `installed_o[b]` is high exactly when block b is configured, its confirmation page is written, and the stored confirmation word equals 32'h8AFE15C3. A confirmation with any other word is stored but does not install.
- R3: `active_o[b]` changes only on `sys_reset_i`, where it takes the value of `installed_o[b]`. An accepted erase of block b also clears it. A configured block that is not confirmed never becomes active.
- R4: Blocks 0 and 1 accept at most 4 erases over the device lifetime. The erase count of block b is in `erase_cnt_o[3b+2:3b]`. The count of block 2 stays 0.
- R5: An erase of block 2 while it is installed is rejected, and the block stays installed.
- R6: An erase of an active block is accepted only if `wp_dis_i[b]` is high. An accepted erase clears the configured flag, the keywords, the protection type and the confirmation page of that block.
- R7: `any_installed_o` is high exactly when at least one `installed_o` bit is high.
- R8: Bit 15 of `ptype_i` is the read-protect bit. It is accepted only for block 0, and a configuration page carrying it for another block is rejected. `rd_prot_o` equals `active_o[0]` AND the stored read-protect bit of block 0.
- R9: `reject_o` is set and the stored state is left unchanged by any of the following: a block index of 3, a nonzero `pad_i` on either page program, a configuration program to a configured block, a confirmation program to an unconfigured or already confirmed block, or an erase refused by R4 to R6. `reject_o` stays high until `sys_reset_i`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; returns all blocks to the erased delivery state |
| sys_reset_i | input | 1 | System reset pulse: latches active flags and clears reject |
| blk_i | input | 2 | Target configuration block index |
| cfg_prog_i | input | 1 | Program configuration page pulse |
| conf_prog_i | input | 1 | Program confirmation page pulse |
| erase_i | input | 1 | Erase configuration block pulse |
| wp_dis_i | input | 3 | Per-block write protection temporarily disabled |
| ptype_i | input | 16 | Protection type; bit 15 is read-protect |
| key0_i | input | 32 | First keyword (stored on configure, compared for key_ok_o) |
| key1_i | input | 32 | Second keyword (stored on configure, compared for key_ok_o) |
| word_i | input | 32 | Confirmation word |
| pad_i | input | 32 | Unused page bytes; must be zero |
| configured_o | output | 3 | Per-block configured flag |
| installed_o | output | 3 | Per-block installed flag |
| active_o | output | 3 | Per-block active flag |
| any_installed_o | output | 1 | Global installed flag |
| rd_prot_o | output | 1 | Read protection active |
| key_ok_o | output | 3 | Stored keywords match key inputs |
| erase_cnt_o | output | 9 | Per-block lifetime erase counts, 3 bits each |
| reject_o | output | 1 | Sticky illegal-request flag |

## Verification
The hardest situations to reach are the fifth erase of block 0 or 1, and an erase of the installed one-time block after a reset has made it active. Both need a long, ordered chain of configure, confirm, reset and erase commands, and random stimulus rarely builds such a chain. Directed sequences therefore build these chains explicitly. A seeded random mix of commands follows, with the block index, the padding, the keyword values and the confirmation word biased toward legal values. A bench model compares every output after each command.

// File: rtl/flash_prot_lifecycle.sv
module flash_prot_lifecycle #(
  parameter int NUM_BLK   = 3,
  parameter int ERASE_MAX = 4,
  parameter int KEY_W     = 32,
  parameter int TYPE_W    = 16,
  parameter int RP_BIT    = 15,
  parameter int OTP_BLK   = 2,
  parameter logic [31:0] MAGIC = 32'h8AFE15C3,
  localparam int SEL_W = (NUM_BLK > 1) ? $clog2(NUM_BLK + 1) : 1,
  localparam int CNT_W = $clog2(ERASE_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sys_reset_i,
  input  logic [SEL_W-1:0]         blk_i,
  input  logic                     cfg_prog_i,
  input  logic                     conf_prog_i,
  input  logic                     erase_i,
  input  logic [NUM_BLK-1:0]       wp_dis_i,
  input  logic [TYPE_W-1:0]        ptype_i,
  input  logic [KEY_W-1:0]         key0_i,
  input  logic [KEY_W-1:0]         key1_i,
  input  logic [31:0]              word_i,
  input  logic [31:0]              pad_i,
  output logic [NUM_BLK-1:0]       configured_o,
  output logic [NUM_BLK-1:0]       installed_o,
  output logic [NUM_BLK-1:0]       active_o,
  output logic                     any_installed_o,
  output logic                     rd_prot_o,
  output logic [NUM_BLK-1:0]       key_ok_o,
  output logic [NUM_BLK*CNT_W-1:0] erase_cnt_o,
  output logic                     reject_o
);

  logic [NUM_BLK-1:0] cfg_q, conf_q, act_q;
  logic [KEY_W-1:0]   k0_q [NUM_BLK];
  logic [KEY_W-1:0]   k1_q [NUM_BLK];
  logic [31:0]        cw_q [NUM_BLK];
  logic [TYPE_W-1:0]  pt_q [NUM_BLK];
  logic [CNT_W-1:0]   cnt_q [NUM_BLK];
  logic               rej_q;

  logic               sel_ok;
  logic [SEL_W-1:0]   sel;
  logic               cfg_ok, conf_ok, er_ok;

  assign sel_ok = 32'(blk_i) < NUM_BLK;
  assign sel    = sel_ok ? blk_i : '0;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_flags
    assign installed_o[b] = cfg_q[b] & conf_q[b] & (cw_q[b] == MAGIC);
    assign key_ok_o[b]    = cfg_q[b] & (k0_q[b] == key0_i) & (k1_q[b] == key1_i);
    assign erase_cnt_o[b*CNT_W +: CNT_W] = cnt_q[b];
  end

  assign configured_o    = cfg_q;
  assign active_o        = act_q;
  assign any_installed_o = |installed_o;
  assign rd_prot_o       = act_q[0] & pt_q[0][RP_BIT];
  assign reject_o        = rej_q;

  assign cfg_ok  = sel_ok && !cfg_q[sel] && (pad_i == '0) &&
                   (!ptype_i[RP_BIT] || sel == '0);
  assign conf_ok = sel_ok && cfg_q[sel] && !conf_q[sel] && (pad_i == '0);
  assign er_ok   = sel_ok &&
                   !(32'(sel) == OTP_BLK && installed_o[sel]) &&
                   !(act_q[sel] && !wp_dis_i[sel]) &&
                   !(32'(sel) != OTP_BLK && 32'(cnt_q[sel]) >= ERASE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      conf_q <= '0;
      act_q  <= '0;
      rej_q  <= 1'b0;
      for (int b = 0; b < NUM_BLK; b++) begin
        k0_q[b]  <= '0;
        k1_q[b]  <= '0;
        cw_q[b]  <= '0;
        pt_q[b]  <= '0;
        cnt_q[b] <= '0;
      end
    end else if (sys_reset_i) begin
      act_q <= installed_o;
      rej_q <= 1'b0;
    end else if (erase_i) begin
      if (er_ok) begin
        cfg_q[sel]  <= 1'b0;
        conf_q[sel] <= 1'b0;
        act_q[sel]  <= 1'b0;
        k0_q[sel]   <= '0;
        k1_q[sel]   <= '0;
        cw_q[sel]   <= '0;
        pt_q[sel]   <= '0;
        if (32'(sel) != OTP_BLK) cnt_q[sel] <= cnt_q[sel] + 1'b1;
      end else begin
        rej_q <= 1'b1;
      end
    end else if (conf_prog_i) begin
      if (conf_ok) begin
        conf_q[sel] <= 1'b1;
        cw_q[sel]   <= word_i;
      end else begin
        rej_q <= 1'b1;
      end
    end else if (cfg_prog_i) begin
      if (cfg_ok) begin
        cfg_q[sel] <= 1'b1;
        k0_q[sel]  <= key0_i;
        k1_q[sel]  <= key1_i;
        pt_q[sel]  <= ptype_i;
      end else begin
        rej_q <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(erase_cnt_o[b*CNT_W +: CNT_W]) <= ERASE_MAX);
    assert_active_needs_install_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active_o[b] |-> installed_o[b]);
    assert_active_on_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o[b]) |-> $past(sys_reset_i));
    assert_unconfig_by_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(configured_o[b]) |-> $past(erase_i));
  end

  assert_otp_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(installed_o[OTP_BLK]) |-> installed_o[OTP_BLK]);
  assert_reject_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reject_o) |-> $past(sys_reset_i));

endmodule

// File: tb/flash_prot_lifecycle_tb.sv
module flash_prot_lifecycle_tb_top;
  localparam logic [31:0] MAGIC = 32'h8AFE15C3;
  localparam logic [31:0] KA = 32'h1234_5678, KB = 32'hCAFE_0001;

  logic clk = 0, rst_n = 0;
  logic sys_reset_i = 0, cfg_prog_i = 0, conf_prog_i = 0, erase_i = 0;
  logic [1:0] blk_i = 0;
  logic [2:0] wp_dis_i = 0;
  logic [15:0] ptype_i = 0;
  logic [31:0] key0_i = 0, key1_i = 0, word_i = 0, pad_i = 0;
  logic [2:0] configured_o, installed_o, active_o, key_ok_o;
  logic any_installed_o, rd_prot_o, reject_o;
  logic [8:0] erase_cnt_o;

  always #5 clk = ~clk;

  flash_prot_lifecycle dut_i (
    .clk(clk), .rst_n(rst_n), .sys_reset_i(sys_reset_i), .blk_i(blk_i),
    .cfg_prog_i(cfg_prog_i), .conf_prog_i(conf_prog_i), .erase_i(erase_i),
    .wp_dis_i(wp_dis_i), .ptype_i(ptype_i), .key0_i(key0_i), .key1_i(key1_i),
    .word_i(word_i), .pad_i(pad_i), .configured_o(configured_o),
    .installed_o(installed_o), .active_o(active_o),
    .any_installed_o(any_installed_o), .rd_prot_o(rd_prot_o),
    .key_ok_o(key_ok_o), .erase_cnt_o(erase_cnt_o), .reject_o(reject_o));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  bit [2:0] m_cfg, m_conf, m_act;
  logic [31:0] m_k0 [3], m_k1 [3], m_cw [3];
  logic [15:0] m_pt [3];
  int m_cnt [3];
  bit m_rej;

  function automatic bit m_inst(int b);
    return m_cfg[b] && m_conf[b] && m_cw[b] == MAGIC;
  endfunction

  function automatic bit m_keyok(int b);
    return m_cfg[b] && m_k0[b] == key0_i && m_k1[b] == key1_i;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_all();
    bit any = 0;
    for (int b = 0; b < 3; b++) begin
      chk("R1 configured", 32'(configured_o[b]), 32'(m_cfg[b]));
      chk("R1 key_ok", 32'(key_ok_o[b]), 32'(m_keyok(b)));
      chk("R2 installed", 32'(installed_o[b]), 32'(m_inst(b)));
      chk("R3 active", 32'(active_o[b]), 32'(m_act[b]));
      chk("R4 erase count", 32'(erase_cnt_o[3*b +: 3]), 32'(m_cnt[b]));
      any |= m_inst(b);
    end
    chk("R7 global installed", 32'(any_installed_o), 32'(any));
    chk("R8 read protect", 32'(rd_prot_o), 32'(m_act[0] & m_pt[0][15]));
    chk("R9 reject", 32'(reject_o), 32'(m_rej));
  endtask

  task automatic model(int kind);
    int b = int'(blk_i);
    bit ok;
    case (kind)
      0: begin
        for (int i = 0; i < 3; i++) m_act[i] = m_inst(i);
        m_rej = 0;
      end
      1: begin
        ok = b < 3 && !(b == 2 && m_inst(2)) && !(m_act[b] && !wp_dis_i[b]) &&
             !(b != 2 && m_cnt[b] >= 4);
        if (ok) begin
          m_cfg[b] = 0; m_conf[b] = 0; m_act[b] = 0;
          m_k0[b] = 0; m_k1[b] = 0; m_cw[b] = 0; m_pt[b] = 0;
          if (b != 2) m_cnt[b]++;
        end else m_rej = 1;
      end
      2: begin
        ok = b < 3 && m_cfg[b] && !m_conf[b] && pad_i == 0;
        if (ok) begin m_conf[b] = 1; m_cw[b] = word_i; end
        else m_rej = 1;
      end
      default: begin
        ok = b < 3 && !m_cfg[b] && pad_i == 0 && (!ptype_i[15] || b == 0);
        if (ok) begin m_cfg[b] = 1; m_k0[b] = key0_i; m_k1[b] = key1_i; m_pt[b] = ptype_i; end
        else m_rej = 1;
      end
    endcase
  endtask

  // kind: 0 sys reset, 1 erase, 2 confirm, 3 configure
  task automatic cmd(int kind, int b, logic [31:0] k0, logic [31:0] k1,
                     logic [31:0] w, logic [15:0] pt, logic [2:0] wp, logic [31:0] pad);
    @(negedge clk);
    blk_i = 2'(b); key0_i = k0; key1_i = k1; word_i = w; ptype_i = pt;
    wp_dis_i = wp; pad_i = pad;
    sys_reset_i = kind == 0; erase_i = kind == 1;
    conf_prog_i = kind == 2; cfg_prog_i = kind == 3;
    model(kind);
    @(negedge clk);
    sys_reset_i = 0; erase_i = 0; conf_prog_i = 0; cfg_prog_i = 0;
    check_all();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_k0[i] = 0; m_k1[i] = 0; m_cw[i] = 0; m_pt[i] = 0; m_cnt[i] = 0;
    end
    m_cfg = 0; m_conf = 0; m_act = 0; m_rej = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();

    // OTP block: install, activate, then refused erase (R5)
    cmd(3, 2, KA, KB, 0, 16'h0003, 0, 0);
    cmd(2, 2, KA, KB, MAGIC, 0, 0, 0);
    chk("R2 otp installed before reset", 32'(installed_o[2]), 1);
    chk("R3 not active before reset", 32'(active_o[2]), 0);
    cmd(0, 0, KA, KB, 0, 0, 0, 0);
    chk("R3 active after reset", 32'(active_o[2]), 1);
    cmd(1, 2, KA, KB, 0, 0, 3'b111, 0);
    chk("R5 otp erase rejected", 32'(reject_o), 1);
    chk("R5 otp still installed", 32'(installed_o[2]), 1);
    cmd(0, 0, KA, KB, 0, 0, 0, 0);

    // read-protect only on block 0 (R8), wrong confirmation word (R2)
    cmd(3, 1, KA, KA, 0, 16'h8000, 0, 0);
    chk("R8 rp on block 1 rejected", 32'(configured_o[1]), 0);
    cmd(0, 0, KA, KB, 0, 0, 0, 0);
    cmd(3, 0, KB, KA, 0, 16'h8001, 0, 0);
    cmd(2, 0, KB, KA, 32'h8AFE15C2, 0, 0, 0);
    chk("R2 wrong word not installed", 32'(installed_o[0]), 0);
    cmd(2, 0, KB, KA, MAGIC, 0, 0, 0);
    chk("R9 second confirmation rejected", 32'(reject_o), 1);
    cmd(0, 0, KB, KA, 0, 0, 0, 0);
    chk("R3 unconfirmed block stays inactive", 32'(active_o[0]), 0);
    cmd(1, 0, KB, KA, 0, 0, 0, 0);
    cmd(3, 0, KB, KA, 0, 16'h8001, 0, 0);
    cmd(2, 0, KB, KA, MAGIC, 0, 0, 0);
    cmd(0, 0, KB, KA, 0, 0, 0, 0);
    chk("R8 read protection active", 32'(rd_prot_o), 1);
    cmd(1, 0, KB, KA, 0, 0, 3'b000, 0);
    chk("R6 erase of active block without disable rejected", 32'(configured_o[0]), 1);
    cmd(1, 0, KB, KA, 0, 0, 3'b001, 0);
    chk("R6 erase clears keywords", 32'(key_ok_o[0]), 0);
    cmd(0, 0, KB, KA, 0, 0, 0, 0);

    // lifetime erase limit on block 1 (R4)
    for (int i = 0; i < 5; i++) cmd(1, 1, KA, KB, 0, 0, 0, 0);
    chk("R4 fifth erase rejected", 32'(erase_cnt_o[5:3]), 4);
    chk("R4 reject on fifth erase", 32'(reject_o), 1);
    cmd(0, 0, KA, KB, 0, 0, 0, 0);

    // seeded random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 800; i++) begin
      int kind, b;
      logic [31:0] pad;
      int r = $urandom_range(0, 99);
      kind = r < 10 ? 0 : r < 40 ? 1 : r < 70 ? 2 : 3;
      b = $urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2);
      pad = $urandom_range(0, 7) == 0 ? $urandom | 32'h1 : 32'h0;
      cmd(kind, b,
          $urandom_range(0, 1) ? KA : KB, $urandom_range(0, 1) ? KA : KB,
          $urandom_range(0, 2) != 0 ? MAGIC : $urandom,
          16'($urandom), 3'($urandom), pad);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule